// File: doc/BRIEF.md
# Reloading Countdown Timer Bank with Interrupt Latching

This block holds four down-counters that advance only on cycles where a tick-enable input is high (the tick is expected at a 2 MHz rate, produced elsewhere). Each counter has a programmable reload value. When a decrement reaches zero, the counter reloads and raises an event. A counter whose value and reload are both zero is idle.

Events from the first two counters latch fixed bits into the status register of interrupt group A. Three groups exist: A, B and fast. Each group has an 8-bit status and an 8-bit mask, and drives one request line that is high while status AND mask is nonzero. Software clears status bits through a write-one-to-clear port and replaces masks through a write port. A one-cycle flag reports that a tick produced a timer event while group A's masked request was nonzero.

Top module: `countdown_irq_bank`

## Requirements
- R1: After reset all counters, reload values, statuses and masks are zero, every request is low, the flag is low, and no counter produces events until a reload is written.
- R2: A reload write of value N (nonzero) to timer k (selected by `reload_sel_i` = k) loads both its count and its reload value with N. The N-th following tick cycle, and no earlier one, produces an event. Cycles without a tick do not count.
- R3: On the tick where a decrement reaches zero, the counter loads its reload value, so events repeat every N ticks. A reload of 1 gives an event on every tick.
- R4: Writing a reload value of zero stops the counter: no further events occur on any tick.
- R5: An event from timer 0 sets status bit 5 (0x20) of group A. An event from timer 1 sets status bit 6 (0x40). Status bits stay set until cleared.
- R6: Events from timers 2 and 3 change no status bit in any group.
- R7: `irq_req_o[g]` is high exactly when group g's status AND its mask is nonzero, with g = 0 for A, 1 for B and 2 for fast. A write or clear that selects group 3 has no effect.
- R8: A clear write sets to zero the selected group's status bits where the data is 1. When a clear and a timer event hit the same bit in the same cycle, the bit ends set.
- R9: `irq_rise_o` is high for exactly the one cycle after a tick edge where a timer-0 or timer-1 event occurred and group A's updated status AND updated mask is nonzero. This includes the case where the bit was already set.
- R10: A mask write replaces the selected group's whole mask with the written data. It takes effect at the same edge as any status update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Counter advance enable |
| reload_we_i | input | 1 | Reload write strobe |
| reload_sel_i | input | 2 | Timer index for the reload write |
| reload_data_i | input | 16 | Reload value |
| mask_we_i | input | 1 | Mask write strobe |
| mask_grp_i | input | 2 | Group index for the mask write |
| mask_data_i | input | 8 | New mask value |
| clr_we_i | input | 1 | Status clear strobe |
| clr_grp_i | input | 2 | Group index for the clear |
| clr_data_i | input | 8 | Bits to clear (1 clears) |
| irq_req_o | output | 3 | Per-group masked request (bit 0 A, 1 B, 2 fast) |
| irq_rise_o | output | 1 | One-cycle flag for a tick that produced an active request |

## Verification
A counter holding a wrong count shows up as a group A request or a flag on the wrong tick. This is visible within one reload period of timer 0 or 1, but only after the mask exposes the bit, so the bench holds a full mask for most of the run. A corrupted status or mask appears on the request lines at the very next edge. Timers 2 and 3 are observable only through the absence of any status change, so the bench runs them while all masks are fully open.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    // Group index encoding used on the write ports and the request vector
    localparam int GRP_A    = 0;
    localparam int GRP_B    = 1;
    localparam int GRP_FAST = 2;

    // Status bit positions in group A set by timer events
    localparam int SRC_BIT_T0 = 5;
    localparam int SRC_BIT_T1 = 6;

    // Status contribution of timer k into group A (zero for timers without a source)
    function automatic logic [7:0] src_bits(input int k);
        logic [7:0] r;
        r = '0;
        if (k == 0) r[SRC_BIT_T0] = 1'b1;
        if (k == 1) r[SRC_BIT_T1] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_we_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic             evt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] dec_d;

    always_comb begin
        st_d  = st_q;
        evt_o = 1'b0;
        dec_d = st_q.cnt - 1'b1;
        if (ld_we_i) begin
            st_d.cnt = ld_val_i;
            st_d.rld = ld_val_i;
        end else if (tick_i && (st_q.cnt != '0 || st_q.rld != '0)) begin
            if (dec_d == '0) begin
                evt_o    = 1'b1;
                st_d.cnt = st_q.rld;
            end else begin
                st_d.cnt = dec_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cdt_irq_group.sv
module cdt_irq_group #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [STAT_W-1:0] clr_i,
    input  logic              msk_we_i,
    input  logic [STAT_W-1:0] msk_i,
    output logic              req_o,
    output logic              hit_o
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] msk;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) st_d.stat = st_q.stat & ~clr_i;
        st_d.stat = st_d.stat | set_i;          // set wins over clear
        if (msk_we_i) st_d.msk = msk_i;
        hit_o = (|set_i) && (|(st_d.stat & st_d.msk));
    end

    assign req_o = |(st_q.stat & st_q.msk);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/countdown_irq_bank.sv
module countdown_irq_bank
    import cdt_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 16,
    parameter int STAT_W  = 8,
    parameter int NUM_GRP = 3,
    localparam int TSEL_W = $clog2(NUM_TMR),
    localparam int GSEL_W = $clog2(NUM_GRP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               reload_we_i,
    input  logic [TSEL_W-1:0]  reload_sel_i,
    input  logic [CNT_W-1:0]   reload_data_i,
    input  logic               mask_we_i,
    input  logic [GSEL_W-1:0]  mask_grp_i,
    input  logic [STAT_W-1:0]  mask_data_i,
    input  logic               clr_we_i,
    input  logic [GSEL_W-1:0]  clr_grp_i,
    input  logic [STAT_W-1:0]  clr_data_i,
    output logic [NUM_GRP-1:0] irq_req_o,
    output logic               irq_rise_o
);
    typedef struct packed {
        logic rise;
    } top_state_t;

    logic [NUM_TMR-1:0] tmr_evt;
    logic [NUM_GRP-1:0] grp_hit;
    logic [STAT_W-1:0]  set_a;
    top_state_t         st_d, st_q;

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        cdt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .ld_we_i  (reload_we_i && (reload_sel_i == TSEL_W'(k))),
            .ld_val_i (reload_data_i),
            .evt_o    (tmr_evt[k])
        );
    end

    always_comb begin
        set_a = '0;
        for (int k = 0; k < NUM_TMR; k++) begin
            if (tmr_evt[k]) set_a = set_a | STAT_W'(src_bits(k));
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [STAT_W-1:0] grp_set;
        if (g == GRP_A) begin : g_src
            assign grp_set = set_a;
        end else begin : g_nosrc
            assign grp_set = '0;
        end
        cdt_irq_group #(.STAT_W(STAT_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (grp_set),
            .clr_we_i (clr_we_i && (clr_grp_i == GSEL_W'(g))),
            .clr_i    (clr_data_i),
            .msk_we_i (mask_we_i && (mask_grp_i == GSEL_W'(g))),
            .msk_i    (mask_data_i),
            .req_o    (irq_req_o[g]),
            .hit_o    (grp_hit[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.rise = |grp_hit;
    end

    assign irq_rise_o = st_q.rise;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/countdown_irq_bank_chk.sv
module countdown_irq_bank_chk #(
    parameter int NUM_TMR = 4,
    parameter int NUM_GRP = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic               mask_we_i,
    input logic [NUM_TMR-1:0] evt,
    input logic [NUM_GRP-1:0] irq_req_o,
    input logic               irq_rise_o
);
    AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |-> tick_i);                                          // R2
    AST_FLAG_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise_o |-> $past(tick_i));                                    // R9
    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise_o |-> irq_req_o[0]);                                     // R9
    AST_REQ_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o[0]) |-> ($past(tick_i) || $past(mask_we_i)));     // R7
    AST_NO_SRC_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o[NUM_GRP-1:1] == '0);                                    // R6
endmodule

bind countdown_irq_bank countdown_irq_bank_chk #(
    .NUM_TMR(NUM_TMR),
    .NUM_GRP(NUM_GRP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .mask_we_i  (mask_we_i),
    .evt        (tmr_evt),
    .irq_req_o  (irq_req_o),
    .irq_rise_o (irq_rise_o)
);

// File: tb/countdown_irq_bank_test.sv
module countdown_irq_bank_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       reload_we_i = 1'b0;
    logic [1:0] reload_sel_i = '0;
    logic [15:0] reload_data_i = '0;
    logic       mask_we_i = 1'b0;
    logic [1:0] mask_grp_i = '0;
    logic [7:0] mask_data_i = '0;
    logic       clr_we_i = 1'b0;
    logic [1:0] clr_grp_i = '0;
    logic [7:0] clr_data_i = '0;
    logic [2:0] irq_req_o;
    logic       irq_rise_o;

    int n_chk = 0;
    int n_bad = 0;

    // Behavioural reference state
    int m_cnt [4];
    int m_rld [4];
    int m_st  [3];
    int m_mk  [3];
    bit m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    countdown_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .reload_we_i(reload_we_i), .reload_sel_i(reload_sel_i), .reload_data_i(reload_data_i),
        .mask_we_i(mask_we_i), .mask_grp_i(mask_grp_i), .mask_data_i(mask_data_i),
        .clr_we_i(clr_we_i), .clr_grp_i(clr_grp_i), .clr_data_i(clr_data_i),
        .irq_req_o(irq_req_o), .irq_rise_o(irq_rise_o)
    );

    always @(posedge clk) begin
        int seta;
        bit ev [4];
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_rld[k] = 0; end
            for (int g = 0; g < 3; g++) begin m_st[g] = 0; m_mk[g] = 0; end
            m_flag = 0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                ev[k] = 0;
                if (reload_we_i && reload_sel_i == k) begin
                    m_cnt[k] = reload_data_i; m_rld[k] = reload_data_i;
                end else if (tick_i && (m_cnt[k] != 0 || m_rld[k] != 0)) begin
                    m_cnt[k] = (m_cnt[k] - 1) & 16'hFFFF;
                    if (m_cnt[k] == 0) begin ev[k] = 1; m_cnt[k] = m_rld[k]; end
                end
            end
            seta = (ev[0] ? 'h20 : 0) | (ev[1] ? 'h40 : 0);
            if (clr_we_i && clr_grp_i < 3) m_st[clr_grp_i] = m_st[clr_grp_i] & ~int'(clr_data_i);
            m_st[0] = m_st[0] | seta;
            if (mask_we_i && mask_grp_i < 3) m_mk[mask_grp_i] = mask_data_i;
            m_flag = (seta != 0) && ((m_st[0] & m_mk[0]) != 0);
        end
    end

    // Per-clock comparison against the reference (R7 requests, R9 flag)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < 3; g++) begin
                n_chk++;
                if (irq_req_o[g] !== ((m_st[g] & m_mk[g]) != 0)) begin
                    n_bad++;
                    $display("FAIL R7 group %0d request: actual %0b expected %0b", g, irq_req_o[g], (m_st[g] & m_mk[g]) != 0);
                end
            end
            n_chk++;
            if (irq_rise_o !== m_flag) begin
                n_bad++;
                $display("FAIL R9 flag: actual %0b expected %0b", irq_rise_o, m_flag);
            end
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tick_i = 0; reload_we_i = 0; mask_we_i = 0; clr_we_i = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic wr_reload(input int k, input int v);
        reload_we_i = 1; reload_sel_i = 2'(k); reload_data_i = 16'(v); step();
    endtask

    task automatic wr_mask(input int g, input int v);
        mask_we_i = 1; mask_grp_i = 2'(g); mask_data_i = 8'(v); step();
    endtask

    task automatic wr_clr(input int g, input int v);
        clr_we_i = 1; clr_grp_i = 2'(g); clr_data_i = 8'(v); step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick_i = 1; step(); end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("R1 reset requests", {1'b0, irq_req_o}, 4'h0);
        chk("R1 reset flag", {3'b0, irq_rise_o}, 4'h0);
        ticks(5);
        chk("R1 idle counters", {1'b0, irq_req_o}, 4'h0);

        wr_mask(0, 'hFF);                          // R10
        wr_reload(0, 3);
        ticks(1);
        step();                                    // non-tick cycle must not count
        ticks(1);
        chk("R2 no early event", {1'b0, irq_req_o}, 4'h0);
        ticks(1);
        chk("R2 R5 timer0 event", {1'b0, irq_req_o}, 4'h1);
        chk("R9 flag set", {3'b0, irq_rise_o}, 4'h1);
        step();
        chk("R9 flag one cycle", {3'b0, irq_rise_o}, 4'h0);

        wr_clr(0, 'h20);
        chk("R8 clear", {1'b0, irq_req_o}, 4'h0);
        ticks(2);
        chk("R3 reload period", {1'b0, irq_req_o}, 4'h0);
        ticks(1);
        chk("R3 periodic event", {1'b0, irq_req_o}, 4'h1);

        wr_reload(0, 0);
        wr_clr(0, 'hFF);
        ticks(10);
        chk("R4 stopped timer", {1'b0, irq_req_o}, 4'h0);

        wr_mask(0, 'h20);
        wr_reload(1, 2);
        ticks(2);
        chk("R5 timer1 bit masked", {1'b0, irq_req_o}, 4'h0);
        chk("R9 no flag when masked", {3'b0, irq_rise_o}, 4'h0);
        wr_reload(1, 0);
        wr_mask(0, 'h40);
        chk("R5 R10 timer1 bit6", {1'b0, irq_req_o}, 4'h1);
        wr_clr(0, 'hFF);

        wr_mask(0, 'hFF); wr_mask(1, 'hFF); wr_mask(2, 'hFF);
        wr_reload(2, 1); wr_reload(3, 1);
        ticks(5);
        chk("R6 timers 2 and 3 silent", {1'b0, irq_req_o}, 4'h0);
        wr_reload(2, 0); wr_reload(3, 0);

        wr_reload(0, 1);
        tick_i = 1; clr_we_i = 1; clr_grp_i = 0; clr_data_i = 'h20; step();
        chk("R8 set wins over clear", {1'b0, irq_req_o}, 4'h1);
        ticks(1);
        chk("R9 flag with bit already set", {3'b0, irq_rise_o}, 4'h1);
        wr_reload(0, 0);
        wr_clr(3, 'hFF);
        chk("R7 group 3 clear ignored", {1'b0, irq_req_o}, 4'h1);
        wr_mask(3, 'h00);
        chk("R7 group 3 mask ignored", {1'b0, irq_req_o}, 4'h1);
        wr_mask(0, 'h00);
        chk("R10 mask replaced", {1'b0, irq_req_o}, 4'h0);

        for (int i = 0; i < 2000; i++) begin
            tick_i = 1'($urandom % 2);
            if ($urandom % 8 == 0) begin
                reload_we_i = 1; reload_sel_i = 2'($urandom); reload_data_i = 16'($urandom % 6);
            end
            if ($urandom % 8 == 0) begin
                mask_we_i = 1; mask_grp_i = 2'($urandom); mask_data_i = 8'($urandom);
            end
            if ($urandom % 6 == 0) begin
                clr_we_i = 1; clr_grp_i = 2'($urandom); clr_data_i = 8'($urandom);
            end
            step();
        end

        step();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule